// File: doc/BRIEF.md
# Pixel Expand and Byte Merge Unit

This block is a small registered datapath for pixel work. It takes two 32-bit operands and a 2-bit opcode, and it produces a 64-bit result one clock after an input strobe. Two operations are available. The widen operation turns four unsigned 8-bit pixels into four 16-bit fixed-point lanes, with four fraction bits below each pixel. The interleave operation zips the bytes of the two operands into one 64-bit word.

Running the interleave operation twice turns packed pixel data into planar data. The caller splits the first result into its upper and lower 32-bit halves, then feeds those halves back as the two operands. The 64-bit result, read as eight bytes, then holds all samples of one component first and all samples of the other component after them.

Top module: `pix_expand_merge`

## Requirements
- R1: While reset (`rst_n` low) is asserted and after it is released, `out_valid` is 0 and `result` is all zeros until the first accepted operation.
- R2: With opcode 2'b01 (widen), byte k of `src_a` goes to bits [11:4] of 16-bit lane k, and every other lane bit is 0. Byte 0 is bits [31:24], and lane 0 is `result` bits [63:48]. `src_b` has no effect on the result.
- R3: With opcode 2'b10 (interleave), the result bytes, reading from bits [63:56] downwards, are a0, b0, a1, b1, a2, b2, a3, b3. Here ak is byte k of `src_a` and bk is byte k of `src_b`, and byte 0 is bits [31:24].
- R4: Take a word A = a0 b0 a1 b1 and a word B = a2 b2 a3 b3. Interleave them, then interleave the upper and lower halves of that result. The final result is a0 a1 a2 a3 b0 b1 b2 b3.
- R5: Opcodes 2'b00 and 2'b11 give an all-zero result.
- R6: `result` and `out_valid` update on the first rising edge that samples `in_valid` high. `out_valid` is high for exactly the cycles that follow a sampled strobe.
- R7: While `in_valid` is low, `result` keeps its last value, whatever the opcode and operands do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and opcode are sampled when high |
| opcode | input | 2 | 01 widen, 10 interleave, others give zero |
| src_a | input | 32 | First operand, byte 0 is the top byte |
| src_b | input | 32 | Second operand |
| out_valid | output | 1 | Result updated on the previous edge |
| result | output | 64 | Registered 64-bit result |

## Verification
The only state in this block is the result register and the valid flag. A fault in either one shows at the ports on the edge right after the strobe. If a lane or byte is misrouted, the next `result` has a wrong byte. If the hold logic is broken, `result` changes in an idle cycle. If the valid flag is stuck or delayed, `out_valid` disagrees with the strobe history within one cycle. The double-interleave test checks the byte order as a whole, so a swap between the two operands also shows up as a wrong planar word.

// File: rtl/pix_expand_merge.sv
module pix_expand_merge #(
  parameter int LANES  = 4,
  parameter int PIX_W  = 8,
  parameter int LANE_W = 16,
  parameter int BIN_PT = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [1:0]                opcode,
  input  logic [LANES*PIX_W-1:0]    src_a,
  input  logic [LANES*PIX_W-1:0]    src_b,
  output logic                      out_valid,
  output logic [LANES*LANE_W-1:0]   result
);
  localparam int SRC_W = LANES * PIX_W;
  localparam int RES_W = LANES * LANE_W;
  localparam logic [1:0] OP_WIDEN = 2'b01;
  localparam logic [1:0] OP_ZIP   = 2'b10;

  logic [RES_W-1:0] widen_w, zip_w;
  logic [RES_W-1:0] next_w;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [PIX_W-1:0]  pa, pb;
    logic [LANE_W-1:0] wide;
    assign pa   = src_a[SRC_W-1-i*PIX_W -: PIX_W];
    assign pb   = src_b[SRC_W-1-i*PIX_W -: PIX_W];
    assign wide = {{(LANE_W-PIX_W){1'b0}}, pa} << BIN_PT;
    assign widen_w[RES_W-1-i*LANE_W -: LANE_W]        = wide;
    assign zip_w[RES_W-1-(2*i)*PIX_W -: PIX_W]        = pa;
    assign zip_w[RES_W-1-(2*i+1)*PIX_W -: PIX_W]      = pb;
  end

  always_comb begin
    case (opcode)
      OP_WIDEN: next_w = widen_w;
      OP_ZIP:   next_w = zip_w;
      default:  next_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_w;
    end
  end

  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  // R6
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (out_valid == $past(in_valid)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(in_valid)) |-> $stable(result));

  // R5
  bad_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(in_valid) && ($past(opcode) == 2'b00 || $past(opcode) == 2'b11))
      |-> (result == '0));

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    // R2
    widen_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(in_valid) && $past(opcode) == OP_WIDEN)
        |-> (result[RES_W-1-k*LANE_W -: LANE_W] ==
             ({{(LANE_W-PIX_W){1'b0}}, $past(src_a[SRC_W-1-k*PIX_W -: PIX_W])} << BIN_PT)));
    // R3
    zip_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(in_valid) && $past(opcode) == OP_ZIP)
        |-> (result[RES_W-1-(2*k)*PIX_W -: PIX_W] == $past(src_a[SRC_W-1-k*PIX_W -: PIX_W])
          && result[RES_W-1-(2*k+1)*PIX_W -: PIX_W] == $past(src_b[SRC_W-1-k*PIX_W -: PIX_W])));
  end
endmodule

// File: tb/sim_pix_expand_merge.sv
module sim_pix_expand_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  opcode = 2'b00;
  logic [31:0] src_a = '0, src_b = '0;
  logic        out_valid;
  logic [63:0] result;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pix_expand_merge u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result));

  function automatic logic [63:0] ref_widen(input logic [31:0] a);
    logic [63:0] r = '0;
    for (int k = 0; k < 4; k++) r[63-16*k -: 16] = {4'h0, a[31-8*k -: 8], 4'h0};
    return r;
  endfunction

  function automatic logic [63:0] ref_zip(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] r;
    for (int k = 0; k < 4; k++) begin
      r[63-16*k -: 8] = a[31-8*k -: 8];
      r[55-16*k -: 8] = b[31-8*k -: 8];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1 result in reset", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
    check("R1 result after reset", result, 64'd0);
  endtask

  task automatic t_widen;
    logic [31:0] pats [3] = '{32'h0180_FF7F, 32'hFFFF_FFFF, 32'h1234_5678};
    for (int i = 0; i < 3; i++) begin
      issue(2'b01, pats[i], 32'hDEAD_BEEF);
      check("R2 widen", result, ref_widen(pats[i]));
      check("R6 valid after widen", {63'd0, out_valid}, 64'd1);
    end
    issue(2'b01, 32'hA5C3_0F81, 32'h0000_0000);
    check("R2 src_b ignored (b=0)", result, 64'h0A50_0C30_00F0_0810);
    issue(2'b01, 32'hA5C3_0F81, 32'hFFFF_FFFF);
    check("R2 src_b ignored (b=ff)", result, 64'h0A50_0C30_00F0_0810);
  endtask

  task automatic t_zip;
    issue(2'b10, 32'h0011_2233, 32'h4455_6677);
    check("R3 interleave", result, 64'h0044_1155_2266_3377);
    issue(2'b10, 32'hFFFF_0000, 32'h0000_FFFF);
    check("R3 interleave edges", result, ref_zip(32'hFFFF_0000, 32'h0000_FFFF));
  endtask

  task automatic t_planar;
    logic [63:0] first;
    issue(2'b10, 32'hA0B0_A1B1, 32'hA2B2_A3B3);
    first = result;
    issue(2'b10, first[63:32], first[31:0]);
    check("R4 two passes give planar", result, 64'hA0A1_A2A3_B0B1_B2B3);
  endtask

  task automatic t_badop;
    issue(2'b01, 32'h1111_1111, 32'h2222_2222);
    issue(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R5 opcode 00 zero", result, 64'd0);
    issue(2'b01, 32'h1111_1111, 32'h2222_2222);
    issue(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R5 opcode 11 zero", result, 64'd0);
  endtask

  task automatic t_hold;
    issue(2'b10, 32'h0102_0304, 32'h0506_0708);
    opcode = 2'b01; src_a = 32'hFFFF_FFFF; src_b = 32'hEEEE_EEEE;
    @(negedge clk);
    check("R6 out_valid drops when idle", {63'd0, out_valid}, 64'd0);
    check("R7 result held while idle", result, 64'h0105_0206_0307_0408);
    opcode = 2'b11;
    @(negedge clk);
    check("R7 result held after opcode change", result, 64'h0105_0206_0307_0408);
  endtask

  task automatic t_burst;
    @(negedge clk);
    in_valid = 1'b1; opcode = 2'b01; src_a = 32'h0102_0304;
    @(negedge clk);
    check("R6 burst first", result, ref_widen(32'h0102_0304));
    check("R6 burst valid 1", {63'd0, out_valid}, 64'd1);
    opcode = 2'b10; src_a = 32'hAABB_CCDD; src_b = 32'h1122_3344;
    @(negedge clk);
    check("R6 burst second", result, ref_zip(32'hAABB_CCDD, 32'h1122_3344));
    check("R6 burst valid 2", {63'd0, out_valid}, 64'd1);
    in_valid = 1'b0;
    @(negedge clk);
    check("R6 burst valid end", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    t_reset();
    t_widen();
    t_zip();
    t_planar();
    t_badop();
    t_hold();
    t_burst();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule